// File: doc/BRIEF.md
# Memory Read Request Sink

This block is a test master for the read side of a memory interface. After reset it waits a programmable number of cycles. It then issues a fixed number of read requests to a memory-side data source, one at a time. Each request presents a start address and a beat count, and the request is held until the source accepts it. The block then absorbs the returned data beats over a valid/ready handshake. Each accepted beat is echoed on a one-cycle capture port, so that a surrounding testbench can compare it. A sticky done flag tells the environment that the final beat of the final request has arrived.

The first request reads from a base address. Each later request starts where the previous one ended: its address is the previous address plus the beat count times the data width in bytes. A new request is not issued until every beat of the current request has been received.

The controller has four states. `ST_DELAY` counts the start delay and moves to `ST_REQUEST` when the delay expires. `ST_REQUEST` drives the request and moves to `ST_BEATS` when the request is accepted. `ST_BEATS` collects data. On the final beat it returns to `ST_REQUEST` if requests remain, and otherwise moves to `ST_FINISHED`, which it never leaves. A synchronous reset returns the controller to `ST_DELAY` from any state.

Top module: `mem_read_sink`

## Requirements
- R1: While `rst` is high and on the cycle after it, `req_valid`, `dat_ready`, `done` and `cap_valid` are all 0.
- R2: `req_valid` first goes high right after the (START_DELAY+1)-th rising clock edge at which `rst` is low.
- R3: The first request carries `req_addr` = BASE_ADDR and `req_len` = REQ_BEATS. The length field gives the number of beats itself, not the count minus one.
- R4: While `req_valid` is high and `req_accept` is low, `req_valid` stays high and `req_addr` and `req_len` do not change on the next cycle.
- R5: A request is taken only on a clock edge where `req_valid` and `req_accept` are both high. On the following cycle `req_valid` is low and `dat_ready` is high.
- R6: `dat_ready` is high exactly while beats of the current request are still expected. A beat is taken only on an edge where `dat_valid` and `dat_ready` are both high. A `dat_valid` presented while `dat_ready` is low produces no capture.
- R7: On the cycle after each accepted beat, `cap_valid` is 1 for exactly one cycle and `cap_data` holds that beat's `dat_data`. Captures come out in arrival order.
- R8: Each request after the first has `req_addr` equal to the previous request's address plus REQ_BEATS*(DATA_W/8).
- R9: The next request is issued on the cycle right after the previous request's final beat. `req_valid` and `dat_ready` are never high together. Exactly NUM_REQ requests are issued per run.
- R10: After the final beat of request NUM_REQ, `done` is 1 and stays 1. From then on, `req_valid` and `dat_ready` stay 0.
- R11: A reset asserted in any state, including mid-transfer, clears `done`, `req_valid` and `dat_ready`. The next run then restarts with the full start delay and from BASE_ADDR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_addr | output | ADDR_W | Start byte address of the current request |
| req_len | output | LEN_W | Beat count of the current request |
| req_valid | output | 1 | Request is being presented |
| req_accept | input | 1 | Source takes the request |
| dat_valid | input | 1 | Source presents a data beat |
| dat_data | input | DATA_W | Data beat from the source |
| dat_ready | output | 1 | Block can take a data beat |
| cap_valid | output | 1 | One-cycle pulse after each accepted beat |
| cap_data | output | DATA_W | Copy of the last accepted beat |
| done | output | 1 | All requests completed; sticky until reset |

## Verification
Several rules are checked by assertions on every cycle:
- a pending request holds its address and length steady;
- an accepted request hands over to the data phase;
- the request and data channels are never open together;
- the beat and delay counters stay inside their bounds;
- done is sticky;
- each address step is exactly one request's byte span.

Other behaviour can only be shown by the bench's scenarios. These are the exact start-delay cycle, the first address, and the contents and order of captured data. They also include the rejection of data offered while the block is not ready, the total request count, and a restart after a reset taken in the middle of a data phase.

// File: rtl/rrs_pkg.sv
package rrs_pkg;

    typedef enum logic [1:0] {
        ST_DELAY    = 2'd0,
        ST_REQUEST  = 2'd1,
        ST_BEATS    = 2'd2,
        ST_FINISHED = 2'd3
    } rrs_state_e;

endpackage

// File: rtl/rrs_delay_timer.sv
module rrs_delay_timer #(
    parameter int unsigned START_DELAY = 0
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    localparam int unsigned CW = $clog2(START_DELAY + 2);

    logic [CW-1:0] cnt_q;

    assign expired = (cnt_q == CW'(START_DELAY));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (run && !expired) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R2
    delay_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(START_DELAY));

endmodule

// File: rtl/rrs_beat_counter.sv
module rrs_beat_counter #(
    parameter int unsigned REQ_BEATS = 4,
    parameter int unsigned DATA_W    = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              beat,
    input  logic [DATA_W-1:0] beat_data,
    output logic              last_beat,
    output logic              cap_valid,
    output logic [DATA_W-1:0] cap_data
);
    localparam int unsigned BW = $clog2(REQ_BEATS + 1);

    logic [BW-1:0] cnt_q;

    assign last_beat = beat && (cnt_q == BW'(REQ_BEATS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (beat) begin
            cnt_q <= last_beat ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_valid <= 1'b0;
            cap_data  <= '0;
        end else begin
            cap_valid <= beat;
            if (beat) begin
                cap_data <= beat_data;
            end
        end
    end

    // R6
    beat_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q < BW'(REQ_BEATS));

endmodule

// File: rtl/rrs_addr_gen.sv
module rrs_addr_gen #(
    parameter int unsigned     ADDR_W    = 32,
    parameter int unsigned     NUM_REQ   = 1,
    parameter longint unsigned BASE_ADDR = 0,
    parameter longint unsigned STEP      = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              advance,
    output logic [ADDR_W-1:0] addr,
    output logic              last_req
);
    localparam int unsigned QW = $clog2(NUM_REQ + 1);

    logic [QW-1:0] idx_q;

    assign last_req = (idx_q == QW'(NUM_REQ - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            addr  <= ADDR_W'(BASE_ADDR);
            idx_q <= '0;
        end else if (advance) begin
            addr <= addr + ADDR_W'(STEP);
            if (!last_req) begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    // R8
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        advance |=> addr == $past(addr) + ADDR_W'(STEP));

endmodule

// File: rtl/mem_read_sink.sv
module mem_read_sink
    import rrs_pkg::*;
#(
    parameter int unsigned     ADDR_W      = 32,
    parameter int unsigned     LEN_W       = 8,
    parameter int unsigned     DATA_W      = 32,
    parameter int unsigned     REQ_BEATS   = 4,
    parameter int unsigned     NUM_REQ     = 1,
    parameter longint unsigned BASE_ADDR   = 0,
    parameter int unsigned     START_DELAY = 0
) (
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] req_addr,
    output logic [LEN_W-1:0]  req_len,
    output logic              req_valid,
    input  logic              req_accept,
    input  logic              dat_valid,
    input  logic [DATA_W-1:0] dat_data,
    output logic              dat_ready,
    output logic              cap_valid,
    output logic [DATA_W-1:0] cap_data,
    output logic              done
);
    localparam longint unsigned BYTES_PER_BEAT = DATA_W / 8;
    localparam longint unsigned REQ_SPAN       = REQ_BEATS * BYTES_PER_BEAT;

    rrs_state_e state_q, state_d;

    logic delay_run, delay_expired;
    logic req_fire, beat, last_beat, last_req;

    assign req_fire = req_valid && req_accept;
    assign beat     = dat_valid && dat_ready;
    assign req_len  = LEN_W'(REQ_BEATS);

    rrs_delay_timer #(
        .START_DELAY(START_DELAY)
    ) u_delay (
        .clk    (clk),
        .rst    (rst),
        .run    (delay_run),
        .expired(delay_expired)
    );

    rrs_beat_counter #(
        .REQ_BEATS(REQ_BEATS),
        .DATA_W   (DATA_W)
    ) u_beats (
        .clk      (clk),
        .rst      (rst),
        .clear    (req_fire),
        .beat     (beat),
        .beat_data(dat_data),
        .last_beat(last_beat),
        .cap_valid(cap_valid),
        .cap_data (cap_data)
    );

    rrs_addr_gen #(
        .ADDR_W   (ADDR_W),
        .NUM_REQ  (NUM_REQ),
        .BASE_ADDR(BASE_ADDR),
        .STEP     (REQ_SPAN)
    ) u_addr (
        .clk     (clk),
        .rst     (rst),
        .advance (last_beat),
        .addr    (req_addr),
        .last_req(last_req)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_DELAY;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_DELAY: begin
                if (delay_expired) state_d = ST_REQUEST;
            end
            ST_REQUEST: begin
                if (req_accept) state_d = ST_BEATS;
            end
            ST_BEATS: begin
                if (last_beat) state_d = last_req ? ST_FINISHED : ST_REQUEST;
            end
            ST_FINISHED: begin
                state_d = ST_FINISHED;
            end
            default: state_d = ST_DELAY;
        endcase
    end

    always_comb begin
        delay_run = 1'b0;
        req_valid = 1'b0;
        dat_ready = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            ST_DELAY:    delay_run = 1'b1;
            ST_REQUEST:  req_valid = 1'b1;
            ST_BEATS:    dat_ready = 1'b1;
            ST_FINISHED: done      = 1'b1;
            default:     delay_run = 1'b0;
        endcase
    end

    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_accept |=> req_valid && $stable(req_addr) && $stable(req_len));

    // R5
    req_handover_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_accept |=> !req_valid && dat_ready);

    // R9
    chan_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && dat_ready));

    // R10
    done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> done && !req_valid && !dat_ready);

endmodule

// File: tb/tb_mem_read_sink.sv
module tb_mem_read_sink;
    localparam int CLK_PERIOD  = 10;
    localparam int ADDR_W      = 32;
    localparam int LEN_W       = 8;
    localparam int DATA_W      = 32;
    localparam int REQ_BEATS   = 4;
    localparam int NUM_REQ     = 3;
    localparam int BASE        = 'h100;
    localparam int START_DELAY = 3;
    localparam int SPAN        = REQ_BEATS * DATA_W / 8;

    logic clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic              rst;
    logic [ADDR_W-1:0] req_addr;
    logic [LEN_W-1:0]  req_len;
    logic              req_valid, req_accept;
    logic              dat_valid, dat_ready;
    logic [DATA_W-1:0] dat_data, cap_data;
    logic              cap_valid, done;

    mem_read_sink #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W), .REQ_BEATS(REQ_BEATS),
        .NUM_REQ(NUM_REQ), .BASE_ADDR(BASE), .START_DELAY(START_DELAY)
    ) dut (
        .clk(clk), .rst(rst), .req_addr(req_addr), .req_len(req_len),
        .req_valid(req_valid), .req_accept(req_accept), .dat_valid(dat_valid),
        .dat_data(dat_data), .dat_ready(dat_ready), .cap_valid(cap_valid),
        .cap_data(cap_data), .done(done)
    );

    int checks = 0;
    int fails  = 0;
    logic [DATA_W-1:0] exp_q[$];
    logic [DATA_W-1:0] mon_exp;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wait_req(output int n);
        n = 0;
        while (!req_valid && n < 100) begin
            tick();
            n++;
        end
    endtask

    // Monitor: compares each capture against the scoreboard queue (R7)
    always @(negedge clk) begin
        if (!rst && cap_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R7 unexpected capture", cap_data, 0);
            end else begin
                mon_exp = exp_q.pop_front();
                chk(cap_data == mon_exp, "R7 capture data", cap_data, mon_exp);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int n;
        rst = 1'b1; req_accept = 1'b0; dat_valid = 1'b0; dat_data = '0;
        @(negedge clk);
        repeat (3) tick();
        // R1
        chk(!req_valid, "R1 req_valid in reset", req_valid, 0);
        chk(!dat_ready, "R1 dat_ready in reset", dat_ready, 0);
        chk(!done, "R1 done in reset", done, 0);
        chk(!cap_valid, "R1 cap_valid in reset", cap_valid, 0);

        // R2 delay; R6 data offered before ready is ignored
        rst = 1'b0; dat_valid = 1'b1; dat_data = 32'hDEAD_BEEF;
        wait_req(n);
        dat_valid = 1'b0;
        chk(n == START_DELAY + 1, "R2 start delay", n, START_DELAY + 1);
        chk(!cap_valid, "R6 no capture while not ready", cap_valid, 0);

        for (int r = 0; r < NUM_REQ; r++) begin
            chk(req_valid, "R9 next request issued", req_valid, 1);
            chk(req_addr == ADDR_W'(BASE + r * SPAN), r == 0 ? "R3 first address" : "R8 address step",
                req_addr, BASE + r * SPAN);
            chk(req_len == LEN_W'(REQ_BEATS), "R3 length", req_len, REQ_BEATS);
            for (int w = 0; w <= r; w++) begin
                tick();
                chk(req_valid && req_addr == ADDR_W'(BASE + r * SPAN) && req_len == LEN_W'(REQ_BEATS),
                    "R4 request held", req_addr, BASE + r * SPAN);
            end
            req_accept = 1'b1;
            tick();
            req_accept = 1'b0;
            chk(!req_valid && dat_ready, "R5 handover", {req_valid, dat_ready}, 1);
            for (int b = 0; b < REQ_BEATS; b++) begin
                if (((b + r) % 2) == 1) begin
                    tick();
                    chk(dat_ready, "R6 ready while beats remain", dat_ready, 1);
                end
                dat_valid = 1'b1;
                dat_data = 32'hA000_0000 + DATA_W'(r * 16 + b);
                exp_q.push_back(dat_data);
                tick();
                dat_valid = 1'b0;
                if (b < REQ_BEATS - 1)
                    chk(dat_ready, "R6 ready mid-request", dat_ready, 1);
                else
                    chk(!dat_ready, "R6 ready drops after last beat", dat_ready, 0);
            end
        end
        chk(done, "R10 done after final beat", done, 1);

        // R10 and R9: no further requests, offered data ignored
        dat_valid = 1'b1; dat_data = 32'h5555_AAAA;
        for (int k = 0; k < 3; k++) begin
            tick();
            chk(done && !req_valid && !dat_ready, "R10 sticky done, idle channels",
                {done, req_valid, dat_ready}, 3'b100);
        end
        dat_valid = 1'b0;
        tick();
        chk(exp_q.size() == 0, "R7 all beats captured", exp_q.size(), 0);

        // R11: reset from finished, then reset mid-transfer
        rst = 1'b1; tick(); rst = 1'b0;
        chk(!done, "R11 done cleared", done, 0);
        wait_req(n);
        chk(n == START_DELAY + 1, "R11 delay restarts", n, START_DELAY + 1);
        chk(req_addr == ADDR_W'(BASE), "R11 address restarts", req_addr, BASE);
        req_accept = 1'b1; tick(); req_accept = 1'b0;
        chk(dat_ready, "R11 in data phase", dat_ready, 1);
        rst = 1'b1; tick();
        chk(!dat_ready && !req_valid && !done, "R11 mid-transfer reset",
            {dat_ready, req_valid, done}, 0);
        rst = 1'b0;
        wait_req(n);
        chk(n == START_DELAY + 1, "R11 delay after mid reset", n, START_DELAY + 1);
        chk(req_addr == ADDR_W'(BASE), "R11 base after mid reset", req_addr, BASE);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule